// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps the program order of instructions in a speculative, dynamically scheduled core. When an instruction issues, it claims the slot at the tail of a circular buffer. The slot number comes back as the tag under which the instruction's result will later be delivered. Execution units finish in any order and place their results on a shared result bus. Each result lands in the slot that its tag names.

Architectural state changes only at the head of the buffer. When the oldest slot holds its result, it retires: a register result goes to the register file write port, a store releases its address and data to memory, and a correctly predicted branch simply leaves. Two cases at the head clear the whole buffer and reset both pointers: a branch that was found mispredicted, and any instruction flagged with an exception. The flush output reports the offending tag and its cause. At most one slot retires per cycle.

Top module: `reorder_commit_buf`

## Requirements
- R1: After reset the buffer is empty (`rob_empty`=1, `rob_full`=0), `alloc_ready`=1, `alloc_tag`=0, and `retire_valid` and `flush` are both 0.
- R2: Each accepted allocation is given the current tail tag on `alloc_tag`. Tags go up by one per allocation and wrap from DEPTH-1 to 0.
- R3: With DEPTH slots occupied, `rob_full`=1 and `alloc_ready`=0. An allocation request in that state is ignored: `alloc_tag` and occupancy do not change.
- R4: Only the head slot may retire, and only once its result has arrived. Results for younger slots do not cause a retirement, and slots retire in allocation order.
- R5: Kind encoding is 0 = register, 1 = store, 2 = branch. A retiring register slot pulses `rf_we` with its destination and value. A retiring store pulses `st_en` with its address and value. A retiring correct branch raises `retire_valid` with neither write. `commit_tag` names the retiring slot.
- R6: At most one slot retires per clock cycle, even when several consecutive slots are complete.
- R7: A complete branch at the head whose result marks it mispredicted (kind 2 with `res_mispred`=1) does the following: it raises `flush` for one cycle with `flush_tag` set to the head tag and `flush_excp`=0; it causes no register or store write; and it leaves the buffer empty with the next allocation tag at 0.
- R8: A complete slot at the head whose result carries `res_excp`=1 flushes in the same way as R7, but with `flush_excp`=1 and `flush_tag` naming the faulting slot.
- R9: A result whose tag names a slot that is not currently allocated (for example, one cleared by a flush) is ignored. It does not mark that slot complete when the slot is allocated again later.
- R10: During a flush cycle, allocation is refused (`alloc_ready`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Issue request for a new slot |
| alloc_kind | input | 2 | Kind of issuing instruction (0 reg, 1 store, 2 branch) |
| alloc_dest | input | REG_W | Destination register of the issuing instruction |
| alloc_ready | output | 1 | A slot can be granted this cycle |
| alloc_tag | output | log2(DEPTH) | Tag granted to the issuing instruction |
| res_valid | input | 1 | Result bus carries a result |
| res_tag | input | log2(DEPTH) | Slot the result belongs to |
| res_value | input | DATA_W | Result value or store data |
| res_addr | input | ADDR_W | Store address |
| res_mispred | input | 1 | Branch resolved as mispredicted |
| res_excp | input | 1 | Instruction raised an exception |
| retire_valid | output | 1 | Head slot retires this cycle |
| commit_tag | output | log2(DEPTH) | Tag of the retiring slot |
| rf_we | output | 1 | Register file write enable |
| rf_addr | output | REG_W | Register file write address |
| rf_data | output | DATA_W | Register file write data |
| st_en | output | 1 | Store release to memory |
| st_addr | output | ADDR_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Whole buffer is discarded this cycle |
| flush_excp | output | 1 | Flush cause: 1 exception, 0 misprediction |
| flush_tag | output | log2(DEPTH) | Tag of the slot that caused the flush |
| rob_full | output | 1 | All slots occupied |
| rob_empty | output | 1 | No slot occupied |

## Verification
A head pointer that drifts from the tail shows up as a wrong `commit_tag` or an out-of-order register write on the very next retirement. The scoreboard compares every retirement against the allocation order, so such a drift is caught at once. A stuck completion bit shows up in one of two ways: as a slot that retires before its result is sent, or as a retirement stream that stalls. Both are caught within a few cycles of the result write. A flush that leaves stale slots or an unreset tail shows up at the next allocation as a non-zero tag or a non-empty flag, and the bench checks this immediately after every flush.

// File: rtl/rob_pkg.sv
package rob_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10
  } rob_kind_e;

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter  int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush_fire,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic             full,
  output logic             empty
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [TAG_W-1:0] LAST_IDX = TAG_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ptr_en;

  function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign ptr_en = flush_fire | alloc_fire | retire_fire;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush_fire) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (retire_fire) head_d = step(head_q);
      if (alloc_fire)  tail_d = step(tail_q);
      case ({alloc_fire, retire_fire})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign full  = (cnt_q == FULL_CNT);
  assign empty = (cnt_q == '0);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R3
  no_alloc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_fire);

  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fire |=> (empty && head_q == '0 && tail_q == '0));

  // R4
  retire_occupied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |-> !empty);

endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
  import rob_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  parameter  int ADDR_W = 16,
  parameter  int REG_W  = 5,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [TAG_W-1:0]  alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              res_mispred,
  input  logic              res_excp,
  input  logic              retire_fire,
  input  logic              flush_fire,
  input  logic [TAG_W-1:0]  head_idx,
  output logic              hd_valid,
  output logic              hd_done,
  output rob_kind_e         hd_kind,
  output logic [REG_W-1:0]  hd_dest,
  output logic [DATA_W-1:0] hd_value,
  output logic [ADDR_W-1:0] hd_addr,
  output logic              hd_mispred,
  output logic              hd_excp
);
  timeunit 1ns;
  timeprecision 100ps;

  logic              valid_a [DEPTH];
  logic              done_a  [DEPTH];
  logic              mis_a   [DEPTH];
  logic              exc_a   [DEPTH];
  rob_kind_e         kind_a  [DEPTH];
  logic [REG_W-1:0]  dest_a  [DEPTH];
  logic [DATA_W-1:0] value_a [DEPTH];
  logic [ADDR_W-1:0] addr_a  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic sel_alloc, sel_res, sel_ret, ctl_en;
    logic v_q, v_d, d_q, d_d, m_q, m_d, e_q, e_d;
    rob_kind_e         k_q;
    logic [REG_W-1:0]  r_q;
    logic [DATA_W-1:0] val_q;
    logic [ADDR_W-1:0] adr_q;

    assign sel_ret   = retire_fire && (head_idx == TAG_W'(i));
    assign sel_alloc = alloc_fire && (alloc_idx == TAG_W'(i));
    // stale results for unallocated slots are dropped here
    assign sel_res   = res_valid && (res_tag == TAG_W'(i)) && v_q && !sel_ret;
    assign ctl_en    = flush_fire | sel_ret | sel_alloc | sel_res;

    always_comb begin
      v_d = v_q;
      d_d = d_q;
      m_d = m_q;
      e_d = e_q;
      if (flush_fire) begin
        v_d = 1'b0;
        d_d = 1'b0;
      end else begin
        if (sel_ret) begin
          v_d = 1'b0;
          d_d = 1'b0;
        end
        if (sel_alloc) begin
          v_d = 1'b1;
          d_d = 1'b0;
          m_d = 1'b0;
          e_d = 1'b0;
        end
        if (sel_res) begin
          d_d = 1'b1;
          m_d = res_mispred;
          e_d = res_excp;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
        m_q <= 1'b0;
        e_q <= 1'b0;
      end else if (ctl_en) begin
        v_q <= v_d;
        d_q <= d_d;
        m_q <= m_d;
        e_q <= e_d;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_alloc) begin
        k_q <= alloc_kind;
        r_q <= alloc_dest;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_res) begin
        val_q <= res_value;
        adr_q <= res_addr;
      end
    end

    assign valid_a[i] = v_q;
    assign done_a[i]  = d_q;
    assign mis_a[i]   = m_q;
    assign exc_a[i]   = e_q;
    assign kind_a[i]  = k_q;
    assign dest_a[i]  = r_q;
    assign value_a[i] = val_q;
    assign addr_a[i]  = adr_q;
  end

  assign hd_valid   = valid_a[head_idx];
  assign hd_done    = done_a[head_idx];
  assign hd_mispred = mis_a[head_idx];
  assign hd_excp    = exc_a[head_idx];
  assign hd_kind    = kind_a[head_idx];
  assign hd_dest    = dest_a[head_idx];
  assign hd_value   = value_a[head_idx];
  assign hd_addr    = addr_a[head_idx];

  // R2
  alloc_free_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> !valid_a[alloc_idx]);

  // R4
  head_done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hd_done |-> hd_valid);

endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import rob_pkg::*;
(
  input  logic      hd_valid,
  input  logic      hd_done,
  input  rob_kind_e hd_kind,
  input  logic      hd_mispred,
  input  logic      hd_excp,
  output logic      retire_fire,
  output logic      flush_fire,
  output logic      flush_is_excp,
  output logic      wr_reg,
  output logic      wr_store
);
  timeunit 1ns;
  timeprecision 100ps;

  logic head_ready, head_fault, bad_branch;

  always_comb begin
    head_ready    = hd_valid && hd_done;
    bad_branch    = (hd_kind == KIND_BRANCH) && hd_mispred;
    head_fault    = hd_excp || bad_branch;
    flush_fire    = head_ready && head_fault;
    retire_fire   = head_ready && !head_fault;
    flush_is_excp = hd_excp;
    wr_reg        = retire_fire && (hd_kind == KIND_REG);
    wr_store      = retire_fire && (hd_kind == KIND_STORE);
  end

endmodule

// File: rtl/reorder_commit_buf.sv
module reorder_commit_buf
  import rob_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int DATA_W = 32,
  parameter  int ADDR_W = 16,
  parameter  int REG_W  = 5,
  localparam int TAG_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [1:0]        alloc_kind,
  input  logic [REG_W-1:0]  alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              res_valid,
  input  logic [TAG_W-1:0]  res_tag,
  input  logic [DATA_W-1:0] res_value,
  input  logic [ADDR_W-1:0] res_addr,
  input  logic              res_mispred,
  input  logic              res_excp,
  output logic              retire_valid,
  output logic [TAG_W-1:0]  commit_tag,
  output logic              rf_we,
  output logic [REG_W-1:0]  rf_addr,
  output logic [DATA_W-1:0] rf_data,
  output logic              st_en,
  output logic [ADDR_W-1:0] st_addr,
  output logic [DATA_W-1:0] st_data,
  output logic              flush,
  output logic              flush_excp,
  output logic [TAG_W-1:0]  flush_tag,
  output logic              rob_full,
  output logic              rob_empty
);
  timeunit 1ns;
  timeprecision 100ps;

  logic [TAG_W-1:0]  head, tail;
  logic              full, empty;
  logic              alloc_fire, retire_fire, flush_fire, flush_is_excp;
  logic              wr_reg, wr_store;
  logic              hd_valid, hd_done, hd_mispred, hd_excp;
  rob_kind_e         hd_kind;
  logic [REG_W-1:0]  hd_dest;
  logic [DATA_W-1:0] hd_value;
  logic [ADDR_W-1:0] hd_addr;

  assign alloc_ready = !full && !flush_fire;
  assign alloc_fire  = alloc_valid && alloc_ready;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .retire_fire (retire_fire),
    .flush_fire  (flush_fire),
    .head        (head),
    .tail        (tail),
    .full        (full),
    .empty       (empty)
  );

  rob_entry_store #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_fire  (alloc_fire),
    .alloc_idx   (tail),
    .alloc_kind  (rob_kind_e'(alloc_kind)),
    .alloc_dest  (alloc_dest),
    .res_valid   (res_valid),
    .res_tag     (res_tag),
    .res_value   (res_value),
    .res_addr    (res_addr),
    .res_mispred (res_mispred),
    .res_excp    (res_excp),
    .retire_fire (retire_fire),
    .flush_fire  (flush_fire),
    .head_idx    (head),
    .hd_valid    (hd_valid),
    .hd_done     (hd_done),
    .hd_kind     (hd_kind),
    .hd_dest     (hd_dest),
    .hd_value    (hd_value),
    .hd_addr     (hd_addr),
    .hd_mispred  (hd_mispred),
    .hd_excp     (hd_excp)
  );

  rob_commit_ctrl u_commit (
    .hd_valid      (hd_valid),
    .hd_done       (hd_done),
    .hd_kind       (hd_kind),
    .hd_mispred    (hd_mispred),
    .hd_excp       (hd_excp),
    .retire_fire   (retire_fire),
    .flush_fire    (flush_fire),
    .flush_is_excp (flush_is_excp),
    .wr_reg        (wr_reg),
    .wr_store      (wr_store)
  );

  assign alloc_tag    = tail;
  assign retire_valid = retire_fire;
  assign commit_tag   = head;
  assign rf_we        = wr_reg;
  assign rf_addr      = hd_dest;
  assign rf_data      = hd_value;
  assign st_en        = wr_store;
  assign st_addr      = hd_addr;
  assign st_data      = hd_value;
  assign flush        = flush_fire;
  assign flush_excp   = flush_is_excp;
  assign flush_tag    = head;
  assign rob_full     = full;
  assign rob_empty    = empty;

  // R5
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, st_en}));

  // R6
  retire_or_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retire_valid && flush));

  // R7
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rob_empty && alloc_tag == '0));

  // R10
  flush_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && alloc_valid) |=> rob_empty);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty |-> !retire_valid && !flush);

endmodule

// File: tb/reorder_commit_buf_test.sv
module reorder_commit_buf_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alloc_valid;
  logic [1:0]  alloc_kind;
  logic [4:0]  alloc_dest;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        res_valid;
  logic [2:0]  res_tag;
  logic [31:0] res_value;
  logic [15:0] res_addr;
  logic        res_mispred, res_excp;
  logic        retire_valid;
  logic [2:0]  commit_tag;
  logic        rf_we;
  logic [4:0]  rf_addr;
  logic [31:0] rf_data;
  logic        st_en;
  logic [15:0] st_addr;
  logic [31:0] st_data;
  logic        flush, flush_excp;
  logic [2:0]  flush_tag;
  logic        rob_full, rob_empty;

  reorder_commit_buf #(.DEPTH(DEPTH), .DATA_W(32), .ADDR_W(16), .REG_W(5)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .res_valid(res_valid), .res_tag(res_tag), .res_value(res_value),
    .res_addr(res_addr), .res_mispred(res_mispred), .res_excp(res_excp),
    .retire_valid(retire_valid), .commit_tag(commit_tag),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
    .flush(flush), .flush_excp(flush_excp), .flush_tag(flush_tag),
    .rob_full(rob_full), .rob_empty(rob_empty)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, n_ret = 0, n_flush = 0;
  int exp_tail = 0;
  bit finished = 0;
  int q[$];
  int          exp_kind [DEPTH];
  int          exp_dest [DEPTH];
  logic [31:0] exp_val  [DEPTH];
  logic [15:0] exp_adr  [DEPTH];
  bit          exp_exc  [DEPTH];

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sync();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(int kind, int dest, bit expect_ok);
    sync();
    alloc_valid = 1'b1;
    alloc_kind  = 2'(kind);
    alloc_dest  = 5'(dest);
    #0.1;
    chk(expect_ok ? "R2" : "R3", "alloc_ready", alloc_ready, expect_ok);
    if (expect_ok) begin
      chk("R2", "alloc_tag", alloc_tag, exp_tail);
      exp_kind[exp_tail] = kind;
      exp_dest[exp_tail] = dest;
      q.push_back(exp_tail);
      exp_tail = (exp_tail + 1) % DEPTH;
    end
    sync();
    alloc_valid = 1'b0;
  endtask

  task automatic do_res(int tag, logic [31:0] val, logic [15:0] adr, bit mis, bit exc);
    sync();
    res_valid   = 1'b1;
    res_tag     = 3'(tag);
    res_value   = val;
    res_addr    = adr;
    res_mispred = mis;
    res_excp    = exc;
    exp_val[tag] = val;
    exp_adr[tag] = adr;
    exp_exc[tag] = exc;
    sync();
    res_valid = 1'b0;
  endtask

  // monitor: pops the expected retirement order and compares
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (retire_valid) begin
        if (q.size() == 0) begin
          chk("R4", "retire with nothing pending", 1, 0);
        end else begin
          int t;
          t = q.pop_front();
          chk("R4", "commit_tag order", commit_tag, t);
          chk("R5", "rf_we", rf_we, exp_kind[t] == 0);
          chk("R5", "st_en", st_en, exp_kind[t] == 1);
          if (exp_kind[t] == 0) begin
            chk("R5", "rf_addr", rf_addr, exp_dest[t]);
            chk("R5", "rf_data", rf_data, exp_val[t]);
          end
          if (exp_kind[t] == 1) begin
            chk("R5", "st_addr", st_addr, exp_adr[t]);
            chk("R5", "st_data", st_data, exp_val[t]);
          end
        end
        n_ret++;
      end
      if (flush) begin
        if (q.size() == 0) begin
          chk("R7", "flush with nothing pending", 1, 0);
        end else begin
          int t;
          t = q[0];
          chk(exp_exc[t] ? "R8" : "R7", "flush_tag", flush_tag, t);
          chk(exp_exc[t] ? "R8" : "R7", "flush_excp", flush_excp, exp_exc[t]);
        end
        chk("R7", "no write on flush", rf_we | st_en, 0);
        chk("R10", "alloc_ready during flush", alloc_ready, 0);
        q.delete();
        exp_tail = 0;
        n_flush++;
      end
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 1'b0; alloc_kind = '0; alloc_dest = '0;
    res_valid = 1'b0; res_tag = '0; res_value = '0; res_addr = '0;
    res_mispred = 1'b0; res_excp = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.1;
    // R1 reset state
    chk("R1", "rob_empty", rob_empty, 1);
    chk("R1", "rob_full", rob_full, 0);
    chk("R1", "alloc_ready", alloc_ready, 1);
    chk("R1", "alloc_tag", alloc_tag, 0);
    chk("R1", "retire_valid", retire_valid, 0);
    chk("R1", "flush", flush, 0);

    // R2 / R4 / R6: out-of-order completion, in-order retirement
    do_alloc(0, 3, 1);
    do_alloc(1, 0, 1);
    do_alloc(0, 7, 1);
    do_res(2, 32'h2222_0002, 16'h0, 0, 0);
    do_res(1, 32'h1111_0001, 16'h4a10, 0, 0);
    wait_cycles(2);
    chk("R4", "no retire before head done", n_ret, 0);
    chk("R4", "retire_valid idle", retire_valid, 0);
    do_res(0, 32'h0000_abcd, 16'h0, 0, 0);
    @(negedge clk); #0.1;
    chk("R6", "one retire first cycle", n_ret, 1);
    @(negedge clk); #0.1;
    chk("R6", "one retire second cycle", n_ret, 2);
    @(negedge clk); #0.1;
    chk("R6", "one retire third cycle", n_ret, 3);
    sync();
    chk("R4", "empty after drain", rob_empty, 1);

    // R3 fill with wrap-around, then refused request
    for (int i = 0; i < DEPTH; i++) do_alloc(i % 3, i + 1, 1);
    chk("R3", "rob_full", rob_full, 1);
    chk("R3", "alloc_ready when full", alloc_ready, 0);
    do_alloc(0, 9, 0);
    chk("R3", "alloc_tag unchanged", alloc_tag, 3);
    chk("R3", "still full", rob_full, 1);
    for (int i = DEPTH - 1; i >= 0; i--)
      do_res((3 + i) % DEPTH, 32'h1000 + 32'(i * 17), 16'h0800 + 16'(i), 0, 0);
    wait_cycles(12);
    chk("R5", "all filled slots retired", n_ret, 11);
    chk("R3", "empty after drain", rob_empty, 1);

    // R7 mispredicted branch at head
    do_alloc(0, 12, 1);
    do_alloc(2, 0, 1);
    do_alloc(0, 13, 1);
    do_res(5, 32'h5555, 16'h0, 0, 0);
    do_res(4, 32'h0, 16'h0, 1, 0);
    do_res(3, 32'h3333, 16'h0, 0, 0);
    wait_cycles(4);
    chk("R7", "flush seen", n_flush, 1);
    chk("R7", "older slot retired", n_ret, 12);
    chk("R7", "empty after flush", rob_empty, 1);
    chk("R7", "tag restarts", alloc_tag, 0);

    // R9 stale result to a flushed tag
    do_res(5, 32'hdead_0005, 16'h0, 0, 0);
    chk("R9", "still empty", rob_empty, 1);
    chk("R9", "no retire", retire_valid, 0);
    for (int i = 0; i < 6; i++) do_alloc(0, 20 + i, 1);
    for (int i = 0; i < 5; i++) do_res(i, 32'h7700 + 32'(i), 16'h0, 0, 0);
    wait_cycles(8);
    chk("R9", "stops at stale tag", n_ret, 17);
    chk("R9", "slot still held", rob_empty, 0);
    chk("R9", "head waiting", retire_valid, 0);
    do_res(5, 32'h7705, 16'h0, 0, 0);
    wait_cycles(3);
    chk("R9", "retired after real result", n_ret, 18);
    chk("R9", "empty", rob_empty, 1);

    // R8 exception at head after an older store
    do_alloc(1, 0, 1);
    do_alloc(0, 30, 1);
    do_alloc(0, 31, 1);
    do_res(7, 32'hbad0_0007, 16'h0, 0, 1);
    do_res(0, 32'h0000_0100, 16'h0, 0, 0);
    do_res(6, 32'h6666_6666, 16'h1234, 0, 0);
    wait_cycles(4);
    chk("R8", "store retired", n_ret, 19);
    chk("R8", "flush seen", n_flush, 2);
    chk("R8", "empty", rob_empty, 1);
    chk("R8", "tag restarts", alloc_tag, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule